// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler

This block derives the serial clock of an I2C master from the system clock. A prescaler divides the system clock by a programmable ratio and produces a one-cycle tick at the reduced rate. A phase counter then counts these ticks to build the low and the high half of each serial clock period. Each half is stretched by a fixed overhead that is selected by the prescaler setting: 7 ticks when the divide value is 0, 6 ticks when it is 1, and 5 ticks when it is 2 or more.

The three divider settings are captured only while the generator is stopped (`run` low). While stopped, the serial clock is released high and every counter rests at zero. When `run` rises, the block starts with a full low phase. It reports the start of each low phase and each high phase with a one-cycle strobe, so a bit engine can shift data in step with the clock. A slave that holds the line low stretches the high phase. During the high phase, ticks count only while the line reads high.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, `scl_drive_low`, `fall_stb` and `rise_stb` are all 0.
- R2: While `run` is 0, `scl_drive_low` stays 0 and neither strobe is asserted. The first clock edge after `run` falls releases the line.
- R3: With no stretching, the low phase (`scl_drive_low` = 1) lasts (LOW + d) × (PSC + 1) system clock cycles.
- R4: With no stretching, the high phase (`scl_drive_low` = 0 while running) lasts (HIGH + d) × (PSC + 1) system clock cycles.
- R5: The overhead d is 7 when PSC = 0, 6 when PSC = 1, and 5 when PSC ≥ 2.
- R6: `cfg_we` loads `psc_in`, `low_in` and `high_in` only when `run` is 0. A write pulse while `run` is 1 leaves the phase lengths unchanged, both during the run and after a restart.
- R7: In the high phase, a prescaler tick counts only if `scl_in` is 1 at that clock edge. Each cycle in which a slave holds `scl_in` low (with PSC = 0) lengthens the high phase by one cycle.
- R8: `fall_stb` is 1 for exactly the first cycle of each low phase. `rise_stb` is 1 for exactly the first cycle of each high phase.
- R9: Dropping `run` in the middle of a phase releases the line on the next edge. A restart then begins a complete low phase from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 runs the generator; 0 holds it stopped and allows configuration |
| cfg_we | input | 1 | Configuration write strobe; honoured only while `run` is 0 |
| psc_in | input | DW | Prescaler value; the tick rate is the clock divided by psc_in + 1 |
| low_in | input | DW | Low-phase count, to which d is added |
| high_in | input | DW | High-phase count, to which d is added |
| scl_in | input | 1 | Sampled serial clock line, already synchronised |
| scl_drive_low | output | 1 | 1 pulls the serial clock line low; 0 releases it |
| fall_stb | output | 1 | One-cycle strobe on the first cycle of a low phase |
| rise_stb | output | 1 | One-cycle strobe on the first cycle of a high phase |

## Verification
Phase lengths are measured with three prescaler settings (0, 1 and 3), each paired with a different low/high count. This gives one case for each of the three overhead values, and it also separates errors that scale with the prescaler from errors in the fixed overhead. A stretched high phase, in which the line is held low for four cycles after release, shows that only ticks seen while the line is high are counted. A configuration write made while running must leave both halves unchanged. An abort in the middle of the low phase, followed by a restart, must produce a full-length low phase, which shows that the counters cleared.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Fixed per-half overhead selected by the prescaler setting.
  function automatic logic [2:0] half_overhead(input logic [15:0] psc);
    if (psc == 16'd0)      half_overhead = 3'd7;
    else if (psc == 16'd1) half_overhead = 3'd6;
    else                   half_overhead = 3'd5;
  endfunction

endpackage

// File: rtl/sclgen_cfg.sv
module sclgen_cfg
  import i2c_sclgen_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [DW-1:0] PSC_RST  = '0,
  parameter logic [DW-1:0] LOW_RST  = DW'(3),
  parameter logic [DW-1:0] HIGH_RST = DW'(3),
  localparam int CW = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cfg_we,
  input  logic [DW-1:0] psc_in,
  input  logic [DW-1:0] low_in,
  input  logic [DW-1:0] high_in,
  output logic [DW-1:0] psc_q,
  output logic [CW-1:0] lo_lim,
  output logic [CW-1:0] hi_lim
);

  // Overhead is folded into the stored limits at load time.
  logic [CW-1:0] ovh_in, ovh_rst;
  assign ovh_in  = {{(CW-3){1'b0}}, half_overhead(16'(psc_in))};
  assign ovh_rst = {{(CW-3){1'b0}}, half_overhead(16'(PSC_RST))};

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q  <= PSC_RST;
      lo_lim <= {1'b0, LOW_RST} + ovh_rst;
      hi_lim <= {1'b0, HIGH_RST} + ovh_rst;
    end else if (cfg_we && !run) begin
      psc_q  <= psc_in;
      lo_lim <= {1'b0, low_in} + ovh_in;
      hi_lim <= {1'b0, high_in} + ovh_in;
    end
  end

  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    run |=> ($stable(psc_q) && $stable(lo_lim) && $stable(hi_lim)));

endmodule

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [DW-1:0] psc,
  output logic          tick
);

  logic [DW-1:0] pcnt;

  assign tick = active && (pcnt == psc);

  always_ff @(posedge clk) begin
    if (rst || !active)   pcnt <= '0;
    else if (pcnt == psc) pcnt <= '0;
    else                  pcnt <= pcnt + 1'b1;
  end

  a_r3_pcnt_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> (pcnt <= psc));

  a_r2_pcnt_idle: assert property (@(posedge clk) disable iff (rst)
    !active |=> (pcnt == '0));

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import i2c_sclgen_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          scl_in,
  input  logic [CW-1:0] lo_lim,
  input  logic [CW-1:0] hi_lim,
  output logic          active,
  output logic          drive_low,
  output logic          fall_stb,
  output logic          rise_stb
);

  phase_e        state;
  logic [CW-1:0] cnt;

  assign active = (state != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      drive_low <= 1'b0;
      fall_stb  <= 1'b0;
      rise_stb  <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (!run) begin
        state     <= PH_IDLE;
        cnt       <= '0;
        drive_low <= 1'b0;
      end else begin
        case (state)
          PH_IDLE: begin
            state     <= PH_LOW;
            cnt       <= '0;
            drive_low <= 1'b1;
            fall_stb  <= 1'b1;
          end
          PH_LOW: begin
            if (tick) begin
              if (cnt == lo_lim - 1'b1) begin
                state     <= PH_HIGH;
                cnt       <= '0;
                drive_low <= 1'b0;
                rise_stb  <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          PH_HIGH: begin
            if (tick && scl_in) begin
              if (cnt == hi_lim - 1'b1) begin
                state     <= PH_LOW;
                cnt       <= '0;
                drive_low <= 1'b1;
                fall_stb  <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: begin
            state     <= PH_IDLE;
            cnt       <= '0;
            drive_low <= 1'b0;
          end
        endcase
      end
    end
  end

  a_r2_stop_release: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!drive_low && !fall_stb && !rise_stb));

  a_r3_low_bound: assert property (@(posedge clk) disable iff (rst)
    (state == PH_LOW) |-> (cnt < lo_lim));

  a_r4_high_bound: assert property (@(posedge clk) disable iff (rst)
    (state == PH_HIGH) |-> (cnt < hi_lim));

  a_r7_stretch_hold: assert property (@(posedge clk) disable iff (rst)
    (state == PH_HIGH && run && !scl_in) |=> $stable(cnt));

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int DW = 16,
  parameter logic [DW-1:0] PSC_RST  = '0,
  parameter logic [DW-1:0] LOW_RST  = DW'(3),
  parameter logic [DW-1:0] HIGH_RST = DW'(3)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cfg_we,
  input  logic [DW-1:0] psc_in,
  input  logic [DW-1:0] low_in,
  input  logic [DW-1:0] high_in,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          fall_stb,
  output logic          rise_stb
);

  localparam int CW = DW + 1;

  logic [DW-1:0] psc_q;
  logic [CW-1:0] lo_lim, hi_lim;
  logic          active, tick;

  sclgen_cfg #(
    .DW(DW), .PSC_RST(PSC_RST), .LOW_RST(LOW_RST), .HIGH_RST(HIGH_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we),
    .psc_in(psc_in), .low_in(low_in), .high_in(high_in),
    .psc_q(psc_q), .lo_lim(lo_lim), .hi_lim(hi_lim)
  );

  sclgen_prescale #(.DW(DW)) u_pre (
    .clk(clk), .rst(rst), .active(active), .psc(psc_q), .tick(tick)
  );

  sclgen_phase #(.DW(DW)) u_phase (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .scl_in(scl_in),
    .lo_lim(lo_lim), .hi_lim(hi_lim), .active(active),
    .drive_low(scl_drive_low), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  a_r8_fall_on_entry: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> (scl_drive_low && !$past(scl_drive_low)));

  a_r8_rise_on_entry: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (!scl_drive_low && $past(scl_drive_low)));

  a_r8_entry_strobed: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> fall_stb);

  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(fall_stb && rise_stb));

endmodule

// File: tb/i2c_scl_gen_tb.sv
module i2c_scl_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic cfg_we = 1'b0;
  logic [DW-1:0] psc_in = '0, low_in = '0, high_in = '0;
  logic stretch = 1'b0;
  logic scl_in;
  logic scl_drive_low, fall_stb, rise_stb;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Open-drain line model: low when driven or held by a stretching slave.
  assign scl_in = ~scl_drive_low & ~stretch;

  i2c_scl_gen #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we),
    .psc_in(psc_in), .low_in(low_in), .high_in(high_in),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, cycles=%0d expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    n_checks = n_checks + 1;
    if (got != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic configure(input int p, input int l, input int h);
    run = 1'b0;
    @(negedge clk);
    psc_in = DW'(p); low_in = DW'(l); high_in = DW'(h);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // Called at a negedge; measures one low and one high phase.
  task automatic measure(input int stretch_n, output int lo, output int hi);
    lo = 0; hi = 0;
    while (!fall_stb) @(negedge clk);
    while (scl_drive_low) begin
      lo++;
      if (lo == 2) check("R8 fall_stb single cycle", fall_stb, 0);
      @(negedge clk);
    end
    check("R8 rise_stb at high entry", rise_stb, 1);
    while (!scl_drive_low) begin
      hi++;
      stretch = (hi <= stretch_n);
      if (hi == 2) check("R8 rise_stb single cycle", rise_stb, 0);
      @(negedge clk);
    end
    stretch = 1'b0;
    check("R8 fall_stb at low entry", fall_stb, 1);
  endtask

  task automatic t_reset;
    check("R1 drive after reset", scl_drive_low, 0);
    check("R1 fall_stb after reset", fall_stb, 0);
    check("R1 rise_stb after reset", rise_stb, 0);
    repeat (5) @(negedge clk);
    check("R2 drive while stopped", scl_drive_low, 0);
    check("R2 strobes while stopped", fall_stb | rise_stb, 0);
  endtask

  task automatic t_period(input int p, input int l, input int h, input int d);
    int lo, hi;
    configure(p, l, h);
    run = 1'b1;
    measure(0, lo, hi);
    check("R3 R5 low phase length", lo, (l + d) * (p + 1));
    check("R4 R5 high phase length", hi, (h + d) * (p + 1));
    measure(0, lo, hi);
    check("R3 second low phase", lo, (l + d) * (p + 1));
    check("R4 second high phase", hi, (h + d) * (p + 1));
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ignore_write;
    int lo, hi;
    configure(0, 2, 3);
    run = 1'b1;
    measure(0, lo, hi);
    psc_in = DW'(3); low_in = DW'(20); high_in = DW'(20);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    measure(0, lo, hi);
    check("R6 low unchanged while running", lo, 9);
    check("R6 high unchanged while running", hi, 10);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    measure(0, lo, hi);
    check("R6 low unchanged after restart", lo, 9);
    check("R6 high unchanged after restart", hi, 10);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stretch;
    int lo, hi;
    configure(0, 2, 3);
    run = 1'b1;
    measure(4, lo, hi);
    check("R7 low not affected", lo, 9);
    check("R7 stretched high length", hi, 14);
    measure(0, lo, hi);
    check("R7 unstretched high after", hi, 10);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort;
    int lo, hi;
    configure(0, 5, 5);
    run = 1'b1;
    while (!fall_stb) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9 low before abort", scl_drive_low, 1);
    run = 1'b0;
    @(negedge clk);
    check("R9 released after abort", scl_drive_low, 0);
    check("R2 R9 no strobe on abort", fall_stb | rise_stb, 0);
    @(negedge clk);
    run = 1'b1;
    measure(0, lo, hi);
    check("R9 full low after restart", lo, 12);
    check("R9 full high after restart", hi, 12);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_period(0, 2, 3, 7);
    t_period(1, 0, 4, 6);
    t_period(3, 1, 0, 5);
    t_ignore_write();
    t_stretch();
    t_abort();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule